// File: doc/BRIEF.md
# Reconfigurable XOR Set-Index Hash

This block turns a cache block address into a set index with a permutation-style XOR function. The function can be changed while the chip runs. Index bit `k` always starts from address bit `k`. A per-bit selector can then fold in one more address bit, taken from the portion of the address above the index field. Every XOR therefore has at most two inputs.

The selectors live in a small configuration register that is loaded whole through a write strobe. Reset clears every selector. In that state the block is plain modulo-power-of-two indexing. The address path is combinational up to an optional output register, chosen by a parameter and present by default.

The block serves as the index stage in front of the tag and data arrays of a cache. A profiling step elsewhere picks a configuration and loads it once. The configuration then stays in place for long stretches.

Top module: `xor_index_hash`

## Requirements
- R1: With every selector at code 0 (the reset state), `set_idx` equals the low `IDX_W` bits of the address.
- R2: A selector holding code 0 leaves its index bit equal to address bit `k`.
- R3: A selector holding code `j+1` (for `0 <= j < ADDR_W-IDX_W`) makes index bit `k` equal to address bit `k` XOR address bit `IDX_W+j`.
- R4: A selector code above `ADDR_W-IDX_W` behaves exactly like code 0.
- R5: The selector for index bit `k` sits in bits `[k*SEL_W +: SEL_W]` of `cfg_data`. The whole field loads on a rising clock edge where `cfg_we` is 1. When `cfg_we` is 0, `cfg_data` is ignored and the stored selectors do not change.
- R6: With `OUT_REG=1`, `set_idx` after a rising edge is the hash of the address present at that edge, computed with the selectors stored before that edge. While reset is asserted, `set_idx` is 0.
- R7: Each selector affects only its own index bit.
- R8: An asynchronous active-low reset returns all selectors to code 0, at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Load strobe for the selector register |
| cfg_data | input | IDX_W*SEL_W | Packed selectors; field k is bits [k*SEL_W +: SEL_W] |
| blk_addr | input | ADDR_W | Block address to hash |
| set_idx | output | IDX_W | Hashed set index |

## Verification
The bench steps every lane through all selector codes, including the single out-of-range code. The other lanes hold unrelated codes at the same time. This exposes an off-by-one in the upper-bit selection, which would XOR the wrong address bit. It also exposes a lane that treated an invalid code as a real tap.

Writes with the strobe low, using different data, confirm that a register with a leaky enable would be caught changing the index. Applying a new configuration in the same cycle as an address checks the ordering of the load against the hash. A design that let the new selectors leak into that result would miscompare. A reset in mid-run checks that the block falls back to plain modulo indexing.

// File: rtl/xh_pkg.sv
package xh_pkg;

    // Bits needed to encode "no XOR" plus one code per upper address bit.
    function automatic int unsigned sel_bits(input int unsigned addr_w, input int unsigned idx_w);
        return $clog2(addr_w - idx_w + 1);
    endfunction

endpackage

// File: rtl/xh_cfg_reg.sv
module xh_cfg_reg #(
    parameter int unsigned LANES = 6,
    parameter int unsigned SEL_W = 3,
    localparam int unsigned CW   = LANES * SEL_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [CW-1:0] data,
    output logic [CW-1:0] cfg_q
);

    typedef struct packed {
        logic [CW-1:0] sel;
    } cfg_st_t;

    cfg_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (we) begin
            st_d.sel = data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cfg_q = st_q.sel;

    // R5: a strobe loads the whole field
    assert_cfg_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> (cfg_q == $past(data)));

    // R5: without a strobe the selectors hold
    assert_cfg_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !we |=> $stable(cfg_q));

endmodule

// File: rtl/xh_lane.sv
module xh_lane #(
    parameter int unsigned N_HI  = 6,
    parameter int unsigned SEL_W = 3
) (
    input  logic             lo_bit,
    input  logic [N_HI-1:0]  hi_bits,
    input  logic [SEL_W-1:0] sel,
    output logic             idx_bit
);

    logic tap;

    // One-of-N_HI tap; code 0 and codes above N_HI leave tap at 0.
    always_comb begin
        tap = 1'b0;
        for (int j = 0; j < int'(N_HI); j++) begin
            if (sel == SEL_W'(j + 1)) begin
                tap = hi_bits[j];
            end
        end
        idx_bit = lo_bit ^ tap;
    end

    always_comb begin
        if (sel == '0 || int'(sel) > int'(N_HI)) begin
            // R2, R4: no XOR for code 0 or an out-of-range code
            assert_lane_noxor_R4: assert (idx_bit == lo_bit);
        end else begin
            // R3: code j+1 taps upper bit j
            assert_lane_tap_R3: assert (idx_bit == (lo_bit ^ hi_bits[int'(sel) - 1]));
        end
    end

endmodule

// File: rtl/xor_index_hash.sv
module xor_index_hash #(
    parameter int unsigned ADDR_W  = 12,
    parameter int unsigned IDX_W   = 6,
    parameter bit          OUT_REG = 1'b1,
    localparam int unsigned N_HI   = ADDR_W - IDX_W,
    localparam int unsigned SEL_W  = xh_pkg::sel_bits(ADDR_W, IDX_W),
    localparam int unsigned CW     = IDX_W * SEL_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [CW-1:0]     cfg_data,
    input  logic [ADDR_W-1:0] blk_addr,
    output logic [IDX_W-1:0]  set_idx
);

    logic [CW-1:0]    cfg_q;
    logic [IDX_W-1:0] hash_c;

    xh_cfg_reg #(
        .LANES (IDX_W),
        .SEL_W (SEL_W)
    ) cfg_i (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (cfg_we),
        .data  (cfg_data),
        .cfg_q (cfg_q)
    );

    for (genvar k = 0; k < int'(IDX_W); k++) begin : g_lane
        xh_lane #(
            .N_HI  (N_HI),
            .SEL_W (SEL_W)
        ) lane_i (
            .lo_bit  (blk_addr[k]),
            .hi_bits (blk_addr[ADDR_W-1:IDX_W]),
            .sel     (cfg_q[k*SEL_W +: SEL_W]),
            .idx_bit (hash_c[k])
        );
    end

    if (OUT_REG) begin : g_oreg
        typedef struct packed {
            logic [IDX_W-1:0] idx;
        } out_st_t;

        out_st_t o_d, o_q;

        always_comb begin
            o_d     = o_q;
            o_d.idx = hash_c;
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                o_q <= '0;
            end else begin
                o_q <= o_d;
            end
        end

        assign set_idx = o_q.idx;

        // R1: all-zero selectors give modulo indexing one cycle later
        assert_modulo_R1: assert property (@(posedge clk) disable iff (!rst_n)
            (cfg_q == '0) |=> (set_idx == $past(blk_addr[IDX_W-1:0])));
    end else begin : g_comb
        assign set_idx = hash_c;
    end

endmodule

// File: tb/xor_index_hash_tb_top.sv
module xor_index_hash_tb_top;

    localparam int AW  = 12;
    localparam int IW  = 6;
    localparam int NHI = AW - IW;
    localparam int SW  = 3;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            cfg_we = 1'b0;
    logic [IW*SW-1:0] cfg_data = '0;
    logic [AW-1:0]   blk_addr = '0;
    logic [IW-1:0]   set_idx;

    int n_vec = 0;
    int n_bad = 0;
    int mdl_sel [IW];

    always #4 clk = ~clk;

    xor_index_hash #(.ADDR_W(AW), .IDX_W(IW), .OUT_REG(1'b1)) dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_we   (cfg_we),
        .cfg_data (cfg_data),
        .blk_addr (blk_addr),
        .set_idx  (set_idx)
    );

    // Reference: matrix form, row = address bit, column = index bit
    function automatic logic [IW-1:0] ref_idx(input logic [AW-1:0] a);
        bit h [AW][IW];
        logic [IW-1:0] r;
        for (int rr = 0; rr < AW; rr++)
            for (int c = 0; c < IW; c++) h[rr][c] = 0;
        for (int c = 0; c < IW; c++) begin
            h[c][c] = 1;
            if (mdl_sel[c] >= 1 && mdl_sel[c] <= NHI) h[IW + mdl_sel[c] - 1][c] = 1;
        end
        r = '0;
        for (int c = 0; c < IW; c++)
            for (int rr = 0; rr < AW; rr++)
                if (h[rr][c]) r[c] = r[c] ^ a[rr];
        return r;
    endfunction

    function automatic logic [IW*SW-1:0] pack(input int s [IW]);
        logic [IW*SW-1:0] v = '0;
        for (int c = 0; c < IW; c++) v[c*SW +: SW] = SW'(s[c]);
        return v;
    endfunction

    task automatic check(input logic [IW-1:0] exp, input string tag);
        n_vec++;
        if (set_idx !== exp) begin
            n_bad++;
            $display("FAIL %s: set_idx=%h expected=%h", tag, set_idx, exp);
        end
    endtask

    task automatic step(input logic [AW-1:0] a, input logic we,
                        input logic [IW*SW-1:0] d, input string tag);
        logic [IW-1:0] exp;
        @(negedge clk);
        blk_addr = a;
        cfg_we   = we;
        cfg_data = d;
        exp = ref_idx(a);          // R6: old selectors apply at this edge
        @(posedge clk);
        if (we) for (int c = 0; c < IW; c++) mdl_sel[c] = int'(d[c*SW +: SW]);
        #1;
        check(exp, tag);
    endtask

    task automatic load(input int s [IW]);
        step(AW'($urandom), 1'b1, pack(s), "R5 load");
    endtask

    initial begin
        #(8 * 150000);
        n_bad++;
        $display("FAIL watchdog: expired, expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        int s [IW];
        for (int c = 0; c < IW; c++) mdl_sel[c] = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check('0, "R6 reset output");
        rst_n = 1'b1;

        // R1: modulo after reset
        for (int i = 0; i < 16; i++) step(AW'($urandom), 1'b0, '0, "R1 modulo");

        // R2 R3 R4 R7: sweep every code on every lane, other lanes mixed
        for (int k = 0; k < IW; k++) begin
            for (int code = 0; code < (1 << SW); code++) begin
                for (int c = 0; c < IW; c++) s[c] = (c * 3 + code + k) % (1 << SW);
                s[k] = code;
                load(s);
                for (int i = 0; i < 4; i++)
                    step(AW'($urandom), 1'b0, '0,
                         code == 0 ? "R2 no xor" : (code > NHI ? "R4 out of range" : "R3 tap"));
                // R7: single lane active, rest zero
                for (int c = 0; c < IW; c++) s[c] = 0;
                s[k] = code;
                load(s);
                for (int i = 0; i < 2; i++) step(AW'($urandom), 1'b0, '0, "R7 lane isolation");
            end
        end

        // R5: data ignored without strobe
        for (int c = 0; c < IW; c++) s[c] = c + 1;
        load(s);
        for (int i = 0; i < 12; i++) step(AW'($urandom), 1'b0, IW*SW'($urandom), "R5 hold");

        // R6: address and load in the same cycle; old selectors apply
        for (int i = 0; i < 20; i++) step(AW'($urandom), 1'b1, IW*SW'($urandom), "R6 load order");

        // R8: reset mid-run returns to modulo
        @(negedge clk);
        cfg_we = 1'b0;
        rst_n  = 1'b0;
        for (int c = 0; c < IW; c++) mdl_sel[c] = 0;
        #1;
        check('0, "R8 reset clears output");
        @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < 10; i++) step(AW'($urandom), 1'b0, '1, "R8 modulo after reset");

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule